// File: doc/BRIEF.md
# Periodic Tick Interrupt Generator

The block divides its module clock by a power of two picked with a 3-bit rate code. Each time a period runs out it sets a sticky event flag. When the enable bit is set, it also raises an interrupt request. Firmware uses the requests as a heartbeat: it counts them to keep time and clears the flag after each one.

Two byte-wide registers are reached through one select line:

- **Control register (select 0):** holds the enable bit and the rate code.
- **Event register (select 1):** shows the flag in its top bit. Writing a one to that bit clears the flag.

A write to the control register always restarts the divider from zero. The period after such a write is therefore exact.

The shortest period is set by the parameter `BASE_SHIFT`. With the default of 12 and an 8 MHz module clock, rate code 4 gives 65536 cycles. That is 8.192 ms, and about 122 periods make one second.

Top module: `tick_irq_gen`

## Requirements
- R1: After reset, both registers read 0x00, `irqReq` is low, and the divider is stopped.
- R2: The control register (select 0) keeps write-data bit 7 as the enable bit and bits 2..0 as the rate code. Bits 6..3 read back as zero.
- R3: Rate code r from 1 to 7 makes the flag set once every 2^(BASE_SHIFT+r) clock cycles. With BASE_SHIFT=12, r=4 gives 65536 cycles.
- R4: Rate code 0 stops the divider, and the flag is never set while this code is in force.
- R5: Any write to the control register resets the divider to zero. The next flag set comes exactly one full period after the edge that took the write. If the write falls in the last cycle of a period, that period's flag set is cancelled.
- R6: The flag sets at the end of a period whether or not the interrupt is enabled. `irqReq` equals the flag ANDed with the enable bit.
- R7: The event register (select 1) reads the flag in bit 7 and zeros in bits 6..0. Writing it with bit 7 = 1 clears the flag. Writing it with bit 7 = 0 has no effect.
- R8: If a period ends in the same cycle as a clearing write to the event register, the flag stays set.
- R9: Writes to the event register never disturb the divider count or the period timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regSel | input | 1 | Register select: 0 = control, 1 = event |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the register chosen by `regSel` |
| irqReq | output | 1 | Interrupt request (flag AND enable) |

## Verification
Two events can land in the same cycle: the end of a divider period and a firmware write. The write may be a flag clear, or a control write that restarts the divider.

The bench starts the divider with a control write and then issues the clear, or a second control write, a varying number of cycles later. This sweeps the write across the terminal cycle.

A behavioural reference model runs in step with the design. Each clock it decides whether the flag must survive (R8), or whether the tick is cancelled by the restart (R5). The flag and request are then compared cycle by cycle.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;

  localparam int RATE_W    = 3;
  localparam int NUM_RATES = 1 << RATE_W;
  localparam int REG_W     = 8;
  localparam int EN_BIT    = 7;
  localparam int FLAG_BIT  = 7;

  typedef enum logic {
    SEL_CTRL  = 1'b0,
    SEL_EVENT = 1'b1
  } reg_sel_e;

  // control -> datapath strobes and levels
  typedef struct packed {
    logic              restart;    // control write this cycle
    logic              flagClear;  // write-1 to event flag this cycle
    logic [RATE_W-1:0] rate;       // current rate code
    logic              enable;     // interrupt enable
  } tick_strobe_t;

endpackage

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl
  import tick_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regSel,
  input  logic [REG_W-1:0]   regWrData,
  input  logic               flagIn,
  output tick_strobe_t       strb,
  output logic [REG_W-1:0]   regRdData
);

  logic              enQ;
  logic [RATE_W-1:0] rateQ;
  logic              ctrlWr;
  logic              eventWr;
  logic              unusedWrBits;

  assign ctrlWr       = regWrEn && (reg_sel_e'(regSel) == SEL_CTRL);
  assign eventWr      = regWrEn && (reg_sel_e'(regSel) == SEL_EVENT);
  assign unusedWrBits = ^regWrData[EN_BIT-1:RATE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      rateQ <= '0;
    end else if (ctrlWr) begin
      enQ   <= regWrData[EN_BIT];
      rateQ <= regWrData[RATE_W-1:0];
    end
  end

  always_comb begin
    strb.restart   = ctrlWr;
    strb.flagClear = eventWr && regWrData[FLAG_BIT];
    strb.rate      = rateQ;
    strb.enable    = enQ;
  end

  always_comb begin
    regRdData = '0;
    if (reg_sel_e'(regSel) == SEL_CTRL) begin
      regRdData[EN_BIT]       = enQ;
      regRdData[RATE_W-1:0]   = rateQ;
    end else begin
      regRdData[FLAG_BIT]     = flagIn;
    end
  end

endmodule

// File: rtl/tick_irq_dpath.sv
module tick_irq_dpath
  import tick_irq_pkg::*;
#(
  parameter int BASE_SHIFT = 12,
  localparam int CNT_W     = BASE_SHIFT + NUM_RATES - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  tick_strobe_t     strb,
  output logic             periodTick,
  output logic             flagQ,
  output logic [CNT_W-1:0] divCount
);

  logic [NUM_RATES-1:0] termVec;
  logic                 running;

  // terminal detect per rate: low BASE_SHIFT+r bits all ones
  assign termVec[0] = 1'b0;
  for (genvar r = 1; r < NUM_RATES; r++) begin : g_term
    assign termVec[r] = &divCount[BASE_SHIFT+r-1:0];
  end

  assign running    = (strb.rate != '0);
  assign periodTick = running && termVec[strb.rate] && !strb.restart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCount <= '0;
    end else if (strb.restart || !running || periodTick) begin
      divCount <= '0;
    end else begin
      divCount <= divCount + 1'b1;
    end
  end

  // set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (periodTick) begin
      flagQ <= 1'b1;
    end else if (strb.flagClear) begin
      flagQ <= 1'b0;
    end
  end

endmodule

// File: rtl/tick_irq_gen.sv
module tick_irq_gen
  import tick_irq_pkg::*;
#(
  parameter int BASE_SHIFT = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             irqReq
);

  localparam int CNT_W = BASE_SHIFT + NUM_RATES - 1;

  tick_strobe_t     strb;
  logic             periodTick;
  logic             flagQ;
  logic [CNT_W-1:0] divCount;

  tick_irq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .flagIn    (flagQ),
    .strb      (strb),
    .regRdData (regRdData)
  );

  tick_irq_dpath #(.BASE_SHIFT(BASE_SHIFT)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .periodTick (periodTick),
    .flagQ      (flagQ),
    .divCount   (divCount)
  );

  assign irqReq = flagQ & strb.enable;

endmodule

// File: rtl/tick_irq_chk.sv
module tick_irq_chk
  import tick_irq_pkg::*;
#(
  parameter int CNT_W = 19
) (
  input logic             clk,
  input logic             rstN,
  input tick_strobe_t     strb,
  input logic             periodTick,
  input logic             flagQ,
  input logic [CNT_W-1:0] divCount,
  input logic             irqReq
);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periodTick && strb.flagClear) |=> flagQ);

  // R7
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.flagClear && !periodTick) |=> !flagQ);

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (divCount == '0));

  // R4
  stopped_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rate == '0) |-> !periodTick);

  // R6
  tick_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodTick |=> flagQ);

  // R6
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (flagQ && strb.enable));

  // R9
  event_wr_keeps_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.flagClear && !strb.restart && (strb.rate != '0) && !periodTick)
      |=> (divCount == $past(divCount) + 1'b1));

endmodule

bind tick_irq_gen tick_irq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .strb       (strb),
  .periodTick (periodTick),
  .flagQ      (flagQ),
  .divCount   (divCount),
  .irqReq     (irqReq)
);

// File: tb/tick_irq_gen_tb_top.sv
module tick_irq_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 4;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       irqReq;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  // reference model state
  int mCnt  = 0;
  int mRate = 0;
  bit mEn   = 1'b0;
  bit mFlag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_irq_gen #(.BASE_SHIFT(BASE)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqReq    (irqReq)
  );

  function automatic logic [7:0] expRead(bit sel);
    logic [7:0] v;
    v = 8'h00;
    if (!sel) begin
      v[7]   = mEn;
      v[2:0] = mRate[2:0];
    end else begin
      v[7] = mFlag;
    end
    return v;
  endfunction

  // apply one cycle at a negedge, compare, then advance model
  task automatic step(bit w, bit sel, logic [7:0] d, string tag);
    bit tick;
    bit ctrlW;
    int per;
    regWrEn   = w;
    regSel    = sel;
    regWrData = d;
    #1;
    vectors++;
    if (irqReq !== (mFlag & mEn)) begin
      misses++;
      $display("FAIL %s irqReq act=%0b exp=%0b at %0t", tag, irqReq, mFlag & mEn, $time);
    end
    if (regRdData !== expRead(sel)) begin
      misses++;
      $display("FAIL %s regRdData act=%02h exp=%02h at %0t", tag, regRdData, expRead(sel), $time);
    end
    ctrlW = w && !sel;
    per   = 1 << (BASE + mRate);
    tick  = (mRate != 0) && (mCnt == per - 1) && !ctrlW;
    if (tick) mFlag = 1'b1;
    else if (w && sel && d[7]) mFlag = 1'b0;
    if (ctrlW) begin
      mEn   = d[7];
      mRate = int'(d[2:0]);
      mCnt  = 0;
    end else if (mRate == 0 || tick) begin
      mCnt = 0;
    end else begin
      mCnt++;
    end
    @(negedge clk);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, regSel, 8'h00, tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    misses++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, both registers read zero while in reset
    step(1'b0, 1'b0, 8'h00, "R1");
    step(1'b0, 1'b1, 8'h00, "R1");
    rstN = 1'b1;
    idle(40, "R1");

    // R2: readback and unused bits
    step(1'b1, 1'b0, 8'hFF, "R2");
    step(1'b0, 1'b0, 8'h00, "R2");
    step(1'b1, 1'b0, 8'h84, "R2");
    step(1'b0, 1'b0, 8'h00, "R2");

    // R3: rate 4 enabled, watch event register
    step(1'b1, 1'b0, 8'h84, "R3");
    regSel = 1'b1;
    idle(300, "R3");

    // R7: write 0 leaves flag, write 1 clears
    step(1'b1, 1'b1, 8'h7F, "R7");
    step(1'b0, 1'b1, 8'h00, "R7");
    step(1'b1, 1'b1, 8'h80, "R7");
    idle(5, "R7");

    // R6: disabled but flag still sets
    step(1'b1, 1'b0, 8'h03, "R6");
    idle(200, "R6");
    step(1'b1, 1'b1, 8'h80, "R6");
    step(1'b1, 1'b0, 8'h81, "R6");
    idle(80, "R6");

    // R4: rate 0 stops divider
    step(1'b1, 1'b0, 8'h80, "R4");
    step(1'b1, 1'b1, 8'h80, "R4");
    idle(3000, "R4");

    // R8: sweep clear across terminal cycle
    for (int off = 28; off < 36; off++) begin
      step(1'b1, 1'b0, 8'h81, "R8");
      step(1'b1, 1'b1, 8'h80, "R8");
      idle(off, "R8");
      step(1'b1, 1'b1, 8'h80, "R8");
      idle(4, "R8");
      step(1'b1, 1'b1, 8'h80, "R8");
    end

    // R5: restart mid-period and at terminal cycle
    step(1'b1, 1'b0, 8'h82, "R5");
    idle(40, "R5");
    step(1'b1, 1'b0, 8'h82, "R5");
    idle(70, "R5");
    for (int off = 28; off < 36; off++) begin
      step(1'b1, 1'b0, 8'h81, "R5");
      step(1'b1, 1'b1, 8'h80, "R5");
      idle(off, "R5");
      step(1'b1, 1'b0, 8'h81, "R5");
      idle(40, "R5");
    end

    // R9: event writes do not disturb divider
    step(1'b1, 1'b0, 8'h81, "R9");
    for (int i = 0; i < 30; i++) begin
      step(1'b1, 1'b1, 8'h00, "R9");
      step(1'b1, 1'b1, 8'h80, "R9");
      idle(3, "R9");
    end

    // R3: every rate code
    for (int r = 1; r < 8; r++) begin
      step(1'b1, 1'b0, 8'h80 | 8'(r), "R3");
      step(1'b1, 1'b1, 8'h80, "R3");
      idle((1 << (BASE + r)) + 4, "R3");
    end

    summary();
  end

endmodule